// File: doc/BRIEF.md
# Bus-Attached Byte Stream Port

This block is a memory-mapped register front end for a byte-oriented serial port. It has an APB slave on one side and two byte streams on the other. Incoming bytes arrive on a valid/ready stream and collect in a receive queue. Software drains the queue by reading the data register. A write to the data register sends one byte out on a transmit stream that carries a valid strobe only.

The register window holds a data register, a read-only status word, a control word, and a timing-divider slot that always reads as zero. Control bits enable the receive side, the transmit side and the two interrupt causes. A single interrupt output pulses for one clock after each enabled event.

Back-pressure works as follows:
- A byte moves on the receive stream in any cycle where `rx_valid` and `rx_ready` are both high.
- `rx_ready` drops only while receive is enabled and the queue is full. Enabled traffic therefore stalls rather than being lost.
- While receive is disabled, `rx_ready` stays high and offered bytes are consumed and thrown away.
- The transmit stream has no ready signal. Whatever is attached to it must take one byte per `tx_valid` cycle.

Top module: `uart_bus_frontend`

## Requirements
- R1: Every APB access completes in its first access cycle. `pready` is always 1 and `pslverr` is always 0.
- R2: After reset the following hold:
  - the control word reads 0;
  - the receive queue is empty;
  - the status word reads 0x0000_0006, which is bit 1 (transmit shifter idle) plus bit 2 (transmit queue idle).
- R3: A write to offset 0x08 stores all 32 bits of `pwdata` as the control word. A read of 0x08 returns that word unchanged.
- R4: A receive byte is queued only while control bit 0 (receive enable) is 1. With that bit at 0, offered bytes are consumed and dropped. Status bit 0 (data ready) is 1 exactly when the queue holds at least one byte.
- R5: `rx_ready` is 0 only while control bit 0 is 1 and the queue holds RX_DEPTH bytes. An offered byte is then held off and never lost.
- R6: A read of offset 0x00 or 0x03 returns the oldest queued byte in bits 7:0, with bits 31:8 zero, and removes that byte. With the queue empty, the read returns 0.
- R7: Status bit 8 is 1 while the queue holds at least RX_DEPTH/2 bytes. Status bit 10 is 1 while it holds RX_DEPTH bytes.
- R8: Consider a write to offset 0x00 or 0x03 while control bit 1 (transmit enable) is 1. In the next cycle `tx_valid` is 1 for exactly one cycle, and `tx_data` equals `pwdata[7:0]`. In every other case no byte is sent.
- R9: `irq` is 1 for one cycle after either of two events:
  - a byte is queued while control bit 2 is 1;
  - a byte is sent while control bit 3 is 1.

  If both events fall in the same cycle, they produce a single pulse.
- R10: Only `paddr[7:0]` is decoded. The following offsets are handled without any effect on state:
  - Writes to status (0x04) and to the divider slot (0x0C) are ignored.
  - Reads of 0x0C, 0x10 and any unmapped offset return 0.
  - Writes to 0x01 and 0x02 send nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) / read (0) |
| paddr | input | ADDR_W | APB address, low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid in the access cycle |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte can be taken |
| tx_valid | output | 1 | One-cycle strobe for a sent byte |
| tx_data | output | 8 | Sent byte |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench fills the queue to its exact depth and checks each failure that this corner can expose:
- a design that counts wrong either drops the extra byte or overwrites the oldest one;
- a design that decodes the flags wrong shows the half or full status bits one entry early or late.

It reads the data register at offset 0x03 as well as 0x00, and reads an empty queue. A decoder that ignores the byte alias, or a pop that does not return zero when the queue is empty, shows up as a wrong `prdata`.

It also makes a receive event coincide with a transmit write. A design that does not merge the two events stretches `irq` over two cycles.

Finally, it writes to the status and divider slots. A design whose decode overlaps would change the control word or the status word.

// File: rtl/uart_fe_pkg.sv
package uart_fe_pkg;
  localparam logic [7:0] OFS_DATA   = 8'h00;
  localparam logic [7:0] OFS_DATA_B = 8'h03;
  localparam logic [7:0] OFS_STAT   = 8'h04;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_DIV    = 8'h0C;

  localparam int CB_RX_EN  = 0;
  localparam int CB_TX_EN  = 1;
  localparam int CB_RX_IRQ = 2;
  localparam int CB_TX_IRQ = 3;

  localparam int SB_READY   = 0;
  localparam int SB_TSHIFT  = 1;
  localparam int SB_TQUEUE  = 2;
  localparam int SB_RX_HALF = 8;
  localparam int SB_RX_FULL = 10;

  typedef enum logic [2:0] {
    SLOT_DATA, SLOT_STAT, SLOT_CTRL, SLOT_DIV, SLOT_NONE
  } slot_e;

  function automatic slot_e decode_slot(input logic [7:0] ofs);
    if (ofs == OFS_DATA || ofs == OFS_DATA_B) return SLOT_DATA;
    if (ofs == OFS_STAT) return SLOT_STAT;
    if (ofs == OFS_CTRL) return SLOT_CTRL;
    if (ofs == OFS_DIV)  return SLOT_DIV;
    return SLOT_NONE;
  endfunction
endpackage

// File: rtl/uart_fe_rx_fifo.sv
module uart_fe_rx_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              half,
  output logic              full
);
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign half    = (count >= CNT_W'(DEPTH / 2));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = slot_q[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wr_ptr == PTR_W'(i)) slot_q[i] <= push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= bump(wr_ptr);
      if (do_pop)  rd_ptr <= bump(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/uart_fe_regs.sv
module uart_fe_regs
  import uart_fe_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        access,
  input  logic        write,
  input  logic [7:0]  ofs,
  input  logic [31:0] wdata,
  input  logic [7:0]  q_head,
  input  logic        q_empty,
  input  logic        q_half,
  input  logic        q_full,
  output logic [31:0] rdata,
  output logic [31:0] ctrl,
  output logic        q_pop,
  output logic        tx_fire
);
  slot_e       slot;
  logic [31:0] status;

  assign slot    = decode_slot(ofs);
  assign q_pop   = access && !write && slot == SLOT_DATA && !q_empty;
  assign tx_fire = access && write && slot == SLOT_DATA && ctrl[CB_TX_EN];

  always_comb begin
    status             = '0;
    status[SB_READY]   = !q_empty;
    status[SB_TSHIFT]  = 1'b1;
    status[SB_TQUEUE]  = 1'b1;
    status[SB_RX_HALF] = q_half;
    status[SB_RX_FULL] = q_full;
  end

  always_comb begin
    unique case (slot)
      SLOT_DATA: rdata = q_empty ? 32'h0 : {24'h0, q_head};
      SLOT_STAT: rdata = status;
      SLOT_CTRL: rdata = ctrl;
      default:   rdata = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   ctrl <= '0;
    else if (access && write && slot == SLOT_CTRL) ctrl <= wdata;
  end
endmodule

// File: rtl/uart_fe_events.sv
module uart_fe_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_taken,
  input  logic       rx_irq_en,
  input  logic       tx_fire,
  input  logic       tx_irq_en,
  input  logic [7:0] tx_byte,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
      irq      <= 1'b0;
    end else begin
      tx_valid <= tx_fire;
      if (tx_fire) tx_data <= tx_byte;
      irq <= (rx_taken && rx_irq_en) || (tx_fire && tx_irq_en);
    end
  end
endmodule

// File: rtl/uart_bus_frontend.sv
module uart_bus_frontend
  import uart_fe_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int RX_DEPTH = 16,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              irq
);
  logic             access, q_pop, q_empty, q_half, q_full, tx_fire, rx_taken;
  logic [7:0]       q_head;
  logic [31:0]      ctrl_q;
  logic [CNT_W-1:0] rx_count;

  assign pready   = 1'b1;
  assign pslverr  = 1'b0;
  assign access   = psel && penable;
  assign rx_ready = !(ctrl_q[CB_RX_EN] && q_full);
  assign rx_taken = rx_valid && rx_ready && ctrl_q[CB_RX_EN];

  uart_fe_rx_fifo #(.DEPTH(RX_DEPTH), .DATA_W(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(rx_taken), .push_data(rx_data),
    .pop(q_pop), .head(q_head), .count(rx_count), .empty(q_empty),
    .half(q_half), .full(q_full)
  );

  uart_fe_regs u_regs (
    .clk(clk), .rst_n(rst_n), .access(access), .write(pwrite),
    .ofs(paddr[7:0]), .wdata(pwdata), .q_head(q_head), .q_empty(q_empty),
    .q_half(q_half), .q_full(q_full), .rdata(prdata), .ctrl(ctrl_q),
    .q_pop(q_pop), .tx_fire(tx_fire)
  );

  uart_fe_events u_evt (
    .clk(clk), .rst_n(rst_n), .rx_taken(rx_taken),
    .rx_irq_en(ctrl_q[CB_RX_IRQ]), .tx_fire(tx_fire),
    .tx_irq_en(ctrl_q[CB_TX_IRQ]), .tx_byte(pwdata[7:0]),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );
endmodule

// File: rtl/uart_bus_frontend_chk.sv
module uart_bus_frontend_chk #(
  parameter int ADDR_W   = 8,
  parameter int RX_DEPTH = 16,
  localparam int CNT_W   = $clog2(RX_DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic              pready,
  input logic              pslverr,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic              irq,
  input logic [31:0]       ctrl_q,
  input logic [CNT_W-1:0]  rx_count
);
  logic data_ofs, wr_data, rd_data, taken;
  assign data_ofs = (paddr[7:0] == 8'h00) || (paddr[7:0] == 8'h03);
  assign wr_data  = psel && penable && pwrite && data_ofs;
  assign rd_data  = psel && penable && !pwrite && data_ofs;
  assign taken    = rx_valid && rx_ready && ctrl_q[0];

  a_r1_zero_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pready && !pslverr);

  a_r5_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> (ctrl_q[0] && rx_count == CNT_W'(RX_DEPTH)));

  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(RX_DEPTH));

  a_r6_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rx_count != '0 && !taken) |=> rx_count == $past(rx_count) - CNT_W'(1));

  a_r8_tx_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(wr_data && ctrl_q[1]));

  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past((taken && ctrl_q[2]) || (wr_data && ctrl_q[1] && ctrl_q[3])));
endmodule

bind uart_bus_frontend uart_bus_frontend_chk #(.ADDR_W(ADDR_W), .RX_DEPTH(RX_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pready(pready), .pslverr(pslverr), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .tx_valid(tx_valid), .irq(irq), .ctrl_q(ctrl_q),
  .rx_count(rx_count)
);

// File: tb/tb_uart_bus_frontend.sv
`timescale 1ns/1ps
module tb_uart_bus_frontend;
  localparam int DEPTH = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [7:0]  paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic        pready, pslverr, rx_valid = 0, rx_ready, tx_valid, irq;
  logic [7:0]  rx_data = 0, tx_data;

  int checks = 0, fails = 0;
  logic [7:0]  mq[$];
  logic [31:0] mctrl = 0;

  always #2 clk = ~clk;

  uart_bus_frontend #(.ADDR_W(8), .RX_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_status(input int n);
    logic [31:0] r = 32'h6;
    if (n > 0) r[0] = 1'b1;
    if (n >= DEPTH / 2) r[8] = 1'b1;
    if (n == DEPTH) r[10] = 1'b1;
    return r;
  endfunction

  function automatic bit is_data(input logic [7:0] a);
    return a == 8'h00 || a == 8'h03;
  endfunction

  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic txv, output logic [7:0] txd,
                      output logic irq_o, output logic late);
    @(negedge clk); psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk); penable = 1; #1;
    rd = prdata;
    chk(pready && !pslverr, "R1 handshake", {pready, pslverr}, 2'b10);
    @(negedge clk); psel = 0; penable = 0;
    txv = tx_valid; txd = tx_data; irq_o = irq;
    @(negedge clk); late = tx_valid | irq;
  endtask

  task automatic do_read(input logic [7:0] a);
    logic [31:0] rd, e; logic txv, irq_o, late; logic [7:0] txd;
    xfer(0, a, 32'h0, rd, txv, txd, irq_o, late);
    if (is_data(a)) e = (mq.size() > 0) ? {24'h0, mq.pop_front()} : 32'h0;
    else if (a == 8'h04) e = exp_status(mq.size());
    else if (a == 8'h08) e = mctrl;
    else e = 32'h0;
    chk(rd === e, is_data(a) ? "R6 data read" : (a == 8'h08 ? "R3 control read" :
        (a == 8'h04 ? "R7 status read" : "R10 zero read")), rd, e);
    chk(!txv && !irq_o, "R8 no event on read", {txv, irq_o}, 0);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] rd; logic txv, irq_o, late; logic [7:0] txd; bit send;
    send = is_data(a) && mctrl[1];
    xfer(1, a, d, rd, txv, txd, irq_o, late);
    chk(txv === send, "R8 tx strobe", txv, send);
    if (send) chk(txd === d[7:0], "R8 tx byte", txd, d[7:0]);
    chk(irq_o === (send && mctrl[3]), "R9 tx irq", irq_o, send && mctrl[3]);
    chk(late === 1'b0, "R9 pulse width", late, 0);
    if (a == 8'h08) mctrl = d;
  endtask

  task automatic do_rx(input logic [7:0] b);
    bit acc, er;
    er  = !(mctrl[0] && mq.size() == DEPTH);
    acc = mctrl[0] && mq.size() < DEPTH;
    @(negedge clk); rx_valid = 1; rx_data = b; #1;
    chk(rx_ready === er, "R5 rx_ready", rx_ready, er);
    @(negedge clk); rx_valid = 0;
    chk(irq === (acc && mctrl[2]), "R9 rx irq", irq, acc && mctrl[2]);
    if (acc) mq.push_back(b);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!tx_valid && !irq && rx_ready, "R2 reset outputs", {tx_valid, irq, rx_ready}, 3'b001);
    do_read(8'h04);                      // R2 status 0x6
    do_read(8'h08);                      // R2 control 0
    do_read(8'h00);                      // R6 empty read returns 0

    do_write(8'h08, 32'hFFFF_FFF0);      // R3 full word, receive/transmit off
    do_read(8'h08);
    do_rx(8'hA5);                        // R4 dropped while disabled
    do_read(8'h04);
    do_write(8'h00, 32'h0000_0055);      // R8 no send while disabled

    do_write(8'h08, 32'h0000_0005);      // R4 receive on with irq
    for (int i = 0; i < DEPTH; i++) begin
      do_rx(8'(8'h10 + i));
      if (i == DEPTH/2 - 2 || i == DEPTH/2 - 1 || i == DEPTH - 2) do_read(8'h04); // R7 edges
    end
    do_read(8'h04);                      // R7 full
    do_rx(8'hEE);                        // R5 stall when full
    do_read(8'h03);                      // R6 alias offset
    do_read(8'h00);
    do_write(8'h04, 32'hFFFF_FFFF);      // R10 status write ignored
    do_read(8'h04);
    do_write(8'h0C, 32'h1234_5678);      // R10 divider slot
    do_read(8'h0C);
    do_read(8'h10);
    do_read(8'hFC);
    do_read(8'h08);
    do_write(8'h01, 32'h77);             // R10 non-data offset sends nothing
    while (mq.size() > 0) do_read(8'h00);
    do_read(8'h04);                      // R4 data ready clear

    // R9 merged pulse: receive and transmit in the same cycle
    do_write(8'h08, 32'h0000_000F);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = 8'h00; pwdata = 32'h3C;
    @(negedge clk); penable = 1; rx_valid = 1; rx_data = 8'hC3;
    @(negedge clk); psel = 0; penable = 0; rx_valid = 0;
    chk(irq === 1'b1 && tx_valid === 1'b1, "R9 merged pulse", {irq, tx_valid}, 2'b11);
    @(negedge clk);
    chk(irq === 1'b0, "R9 merged single cycle", irq, 0);
    mq.push_back(8'hC3);
    do_read(8'h00);

    for (int n = 0; n < 600; n++) begin
      int op = $urandom_range(0, 6);
      case (op)
        0, 1:    do_rx(8'($urandom));
        2:       do_read($urandom_range(0, 1) ? 8'h00 : 8'h03);
        3:       do_write($urandom_range(0, 1) ? 8'h00 : 8'h03, $urandom);
        4:       do_write(8'h08, {$urandom_range(0, 15) == 0 ? 32'h0 : ($urandom & 32'hFFFF_FFF0)} |
                                 32'($urandom_range(0, 15)) | 32'h1);
        5:       do_read(8'h04);
        default: do_read(8'h08);
      endcase
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule